// File: doc/BRIEF.md
# One-of-N Clock Enable Gater

This block produces the enable qualifiers that let a peripheral's channel logic advance at a reduced rate while the rest of the peripheral stays on the full interface clock. A two-bit ratio code selects a power-of-two divisor N of 1, 2, 4 or 8. The block emits a channel strobe that is high in one interface-clock cycle out of every N. For N equal to 1, the strobe stays high, so the channel logic runs free.

A second output qualifies the interface clock of the bus-side logic. When the auto-idle control is set and the module is disabled, that enable drops so the interface clock can be gated. When auto-idle is clear, the enable stays on regardless of any other setting. The module-disable input stops the channel strobe and parks the internal divide counter at zero. A change of ratio code restarts the divide sequence, so the first strobe at the new rate arrives a full period later. The actual gating cells belong to the surrounding logic.

Top module: `clk_en_gater`

## Requirements
- R1: `ratio_sel` encodes the divisor as 2 to the power of its value: 0 gives N=1, 1 gives N=2, 2 gives N=4, 3 gives N=8.
- R2: With N=1 and the module enabled, `chan_en` is high in every cycle.
- R3: With N greater than 1 and no change of configuration, `chan_en` is high in exactly one cycle of every N consecutive cycles, with N-1 low cycles between strobes.
- R4: While `mod_disable` is high, `chan_en` is low and the divide counter is held at zero. After release, the first strobe comes in the N-th cycle, where the release cycle counts as the first.
- R5: In the cycle in which `ratio_sel` differs from the value it had at the previous clock edge, `chan_en` is low. The counter restarts at that edge, so the next strobe falls N cycles after the edge.
- R6: When `auto_idle` and `mod_disable` are both high, `ifc_clk_en` is low. With `auto_idle` high and `mod_disable` low, it is high.
- R7: When `auto_idle` is low, `ifc_clk_en` is high whatever the other inputs are.
- R8: After reset is released with `ratio_sel` at 0, `chan_en` and `ifc_clk_en` are high in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | SEL_W | Divisor code, N = 2**ratio_sel |
| auto_idle | input | 1 | Allows the interface clock enable to drop while disabled |
| mod_disable | input | 1 | Stops channel activity |
| chan_en | output | 1 | One-of-N channel clock-enable strobe |
| ifc_clk_en | output | 1 | Interface clock enable for the bus-side logic |

## Verification
The bench builds the block with the default `SEL_W` of 2. This places all four divisor codes within reach, including the widest 3-bit counter wrap at N=8. Every code is entered from a different previous code, so each entry goes through a restart, and one restart happens in the middle of a count. The strobe pattern is then compared against a modulo-N position for several periods. Disable and release are exercised at N=4, so the hold at zero can be seen in the timing of the first strobe after release.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    DIV_BY_1 = 2'd0,
    DIV_BY_2 = 2'd1,
    DIV_BY_4 = 2'd2,
    DIV_BY_8 = 2'd3
  } ratio_e;

  // terminal count of the divide sequence for a given ratio code
  function automatic int ratio_last(input int code);
    return (1 << code) - 1;
  endfunction

endpackage

// File: rtl/ratio_tracker.sv
module ratio_tracker #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic [SEL_W-1:0] ratio_q,
  output logic             ratio_chg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ratio_q <= '0;
    else        ratio_q <= ratio_sel;
  end

  // a code differing from the one latched at the last edge is a change
  assign ratio_chg = (ratio_sel != ratio_q);

endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] ratio_q,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  import clkgate_pkg::*;

  logic [CNT_W-1:0] last_v;

  assign last_v  = CNT_W'(ratio_last(int'(ratio_q)));
  assign at_last = (cnt == last_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  // R3: without a restart the counter never runs past the terminal count
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt <= last_v));

  // R4: a restart request leaves the counter at zero
  a_r4_cnt_parked: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/idle_gate.sv
module idle_gate (
  input  logic auto_idle,
  input  logic mod_disable,
  output logic ifc_clk_en
);

  // auto-idle decides first: when clear the interface clock always runs
  always_comb begin
    if (!auto_idle) ifc_clk_en = 1'b1;
    else            ifc_clk_en = !mod_disable;
  end

endmodule

// File: rtl/clk_en_gater.sv
module clk_en_gater #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             auto_idle,
  input  logic             mod_disable,
  output logic             chan_en,
  output logic             ifc_clk_en
);

  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [SEL_W-1:0] ratio_q;
  logic             ratio_chg;
  logic             cnt_clear;
  logic [CNT_W-1:0] cnt;
  logic             at_last;

  ratio_tracker #(.SEL_W(SEL_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ratio_q   (ratio_q),
    .ratio_chg (ratio_chg)
  );

  assign cnt_clear = mod_disable | ratio_chg;

  div_counter #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .ratio_q (ratio_q),
    .cnt     (cnt),
    .at_last (at_last)
  );

  idle_gate u_idle (
    .auto_idle   (auto_idle),
    .mod_disable (mod_disable),
    .ifc_clk_en  (ifc_clk_en)
  );

  assign chan_en = !mod_disable && !ratio_chg && at_last;

  // R2: divide-by-one runs free while enabled
  a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_disable && ratio_sel == '0 && $past(ratio_sel) == '0) |-> chan_en);

  // R3: with N above one a strobe is followed by a low cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ratio_sel != '0) |=> !chan_en);

  // R4: disabled module produces no strobe
  a_r4_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    mod_disable |-> !chan_en);

  // R5: the cycle carrying a new ratio code has no strobe
  a_r5_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ratio_sel != $past(ratio_sel)) |-> !chan_en);

  // R6: auto-idle with the module disabled drops the interface enable
  a_r6_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_idle && mod_disable) |-> !ifc_clk_en);

  // R7: without auto-idle the interface enable stays on
  a_r7_idle_on: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_idle |-> ifc_clk_en);

endmodule

// File: tb/clk_en_gater_bench.sv
module clk_en_gater_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic       auto_idle = 1'b0;
  logic       mod_disable = 1'b0;
  logic       chan_en;
  logic       ifc_clk_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  clk_en_gater #(.SEL_W(2)) u_clk_en_gater (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel   (ratio_sel),
    .auto_idle   (auto_idle),
    .mod_disable (mod_disable),
    .chan_en     (chan_en),
    .ifc_clk_en  (ifc_clk_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ratio_sel = 2'd0; auto_idle = 1'b0; mod_disable = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    check("R8 chan_en after reset", chan_en, 1'b1);
    check("R8 ifc_clk_en after reset", ifc_clk_en, 1'b1);
  endtask

  task automatic t_free_run();
    for (int i = 0; i < 16; i++) begin
      step();
      check("R2 free run", chan_en, 1'b1);
    end
  endtask

  // enter a new code and compare the strobe pattern with position mod N
  task automatic t_ratio(input logic [1:0] sel);
    int n;
    int strobes;
    n = 1 << sel;
    strobes = 0;
    ratio_sel = sel;
    #1;
    check("R5 change cycle quiet", chan_en, 1'b0);
    step();
    for (int i = 0; i < 4 * n; i++) begin
      check("R1 R3 strobe position", chan_en, (i % n) == n - 1);
      if (chan_en) strobes++;
      step();
    end
    n_tests++;
    if (strobes != 4) begin
      n_fail++;
      $display("FAIL R3 strobe count N=%0d: actual %0d expected 4", n, strobes);
    end
  endtask

  // restart in the middle of a count at N=8 toward N=2
  task automatic t_change_mid();
    ratio_sel = 2'd3;
    #1;
    step();
    repeat (3) step();
    ratio_sel = 2'd1;
    #1;
    check("R5 mid-count change quiet", chan_en, 1'b0);
    step();
    for (int i = 0; i < 6; i++) begin
      check("R5 restart pattern", chan_en, (i % 2) == 1);
      step();
    end
  endtask

  task automatic t_disable();
    ratio_sel = 2'd2;
    #1;
    step();
    repeat (2) step();
    mod_disable = 1'b1;
    #1;
    for (int i = 0; i < 6; i++) begin
      check("R4 disabled strobe low", chan_en, 1'b0);
      step();
    end
    mod_disable = 1'b0;
    #1;
    for (int i = 0; i < 8; i++) begin
      check("R4 release from zero", chan_en, (i % 4) == 3);
      step();
    end
  endtask

  task automatic t_idle();
    auto_idle = 1'b1; mod_disable = 1'b1;
    #1;
    check("R6 auto-idle disabled", ifc_clk_en, 1'b0);
    step();
    check("R6 auto-idle disabled held", ifc_clk_en, 1'b0);
    mod_disable = 1'b0;
    #1;
    check("R6 auto-idle enabled", ifc_clk_en, 1'b1);
    auto_idle = 1'b0; mod_disable = 1'b1;
    #1;
    check("R7 no auto-idle disabled", ifc_clk_en, 1'b1);
    step();
    mod_disable = 1'b0;
    #1;
    check("R7 no auto-idle enabled", ifc_clk_en, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_ratio(2'd1);
    t_ratio(2'd2);
    t_ratio(2'd3);
    t_ratio(2'd0);
    t_change_mid();
    t_disable();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule